// File: doc/BRIEF.md
# PWM Channel with Event-Driven Action Qualifier

This block is one pulse-width modulation channel. A prescaled time base counts up, down or up and then down between zero and a programmed period. At every counter step it notes four events: arrival at zero, arrival at the period value, and a compare match reached while rising or while falling. Each event carries a two-bit action that leaves the waveform alone, clears it, sets it or flips it. The waveform is therefore shaped by an action table and not by a single threshold. A final stage can invert the level, and a mask can override it with a fixed level.

Software writes the period and compare inputs at any time. The time base copies them into its working registers only when a new period begins, so a period that is already running is never cut short. A period of zero parks the counter. A one-cycle clear request restarts the counter from the beginning of a period on the next tick.

The time base is a three-state machine. TB_IDLE holds the count at 0. TB_RISE counts upward and TB_FALL counts downward. The transition start leaves TB_IDLE on the first tick: it goes to TB_FALL at the period value in down mode, and to TB_RISE at 0 in the other modes. The transition wrap stays in TB_RISE in up mode (period value to 0), and reload stays in TB_FALL in down mode (0 to period value). The transition turn goes from TB_RISE to TB_FALL at the peak in up-down mode. The transition rebound goes from TB_FALL to TB_RISE on reaching 0 in up-down mode. The transition park returns to TB_IDLE on enable low, on clear, or when a new period would begin with a zero period value.

Top module: `pwm_aq_channel`

## Requirements
- R1: The cfg_mode encoding is 0 = up, 1 = down, 2 = up-down, and 3 behaves as up. With period P, up mode counts 0,1,..,P and then wraps to 0. Down mode starts at P, counts down to 0 and then reloads P. Up-down mode counts 0 up to P and back down to 0. The first tick after idle enters 0 (up and up-down) or P (down).
- R2: While en is high, the count steps once every cfg_prescale+1 clock cycles. The first step comes on the (cfg_prescale+1)-th rising edge at which en is high.
- R3: Each event output is high for exactly one cycle, in the cycle in which the count has just entered the value that defines it. ev_zero marks entry to 0 and ev_period marks entry to P; in up-down mode ev_period fires once per peak. ev_cmp_up marks entry to the compare value on an upward step, and the start step from idle counts as upward. ev_cmp_down marks entry to the compare value on a downward step, and the down-mode reload counts as downward.
- R4: Action code 0 keeps the waveform, 1 drives it low, 2 drives it high and 3 toggles it. The waveform changes in the same cycle as the event strobe.
- R5: When events coincide in one step, the zero or period action is applied first and the compare action is then applied to that result.
- R6: cfg_period and cfg_compare are copied into the working registers only when a period begins: at the start from idle, at the up-mode wrap, at the down-mode reload, and at the up-down return to 0. The events of that step already use the new values.
- R7: If a new period would begin while cfg_period is 0, the counter stays at 0 with no events.
- R8: While en is low, the count is 0, no event fires and the waveform holds its level.
- R9: A cnt_clear pulse sets the count to 0 and restarts the prescaler and the time base, as when starting from idle.
- R10: With cfg_invert high, pwm_out is the inverse of the waveform.
- R11: With cfg_mask_en high, pwm_out equals cfg_mask_level whatever the inversion.
- R12: After reset, the count is 0, all events are low and the waveform is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| cnt_clear | input | 1 | Single-cycle counter restart request |
| cfg_mode | input | 2 | Counting mode |
| cfg_prescale | input | 12 | Clock divide minus one |
| cfg_period | input | 16 | Period value (buffered) |
| cfg_compare | input | 16 | Compare value (buffered) |
| act_zero | input | 2 | Action on reaching zero |
| act_period | input | 2 | Action on reaching the period value |
| act_cmp_up | input | 2 | Action on a rising compare match |
| act_cmp_down | input | 2 | Action on a falling compare match |
| cfg_invert | input | 1 | Output polarity inversion |
| cfg_mask_en | input | 1 | Force the output to the mask level |
| cfg_mask_level | input | 1 | Forced output level |
| pwm_out | output | 1 | Waveform output |
| cnt_value | output | 16 | Current count |
| ev_zero | output | 1 | Zero event strobe |
| ev_period | output | 1 | Period event strobe |
| ev_cmp_up | output | 1 | Rising compare event strobe |
| ev_cmp_down | output | 1 | Falling compare event strobe |

## Verification
Count, event strobes and waveform level all update on the rising edge at which the prescaler tick is taken, so each is due one edge after the inputs that caused it. Enable-low and clear act on the very next edge, and pwm_out follows inversion and mask without any register delay. The bench drives inputs on falling edges and advances an arithmetic model of the channel on each rising edge. It compares every output with that model on the next falling edge, which keeps every check exactly one edge behind its stimulus.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int CNT_W  = 16;
    localparam int PSC_W  = 12;
    localparam int NUM_EV = 4;

    // Event slots, listed in the order their actions are applied
    localparam int EV_ZERO = 0;
    localparam int EV_PEAK = 1;
    localparam int EV_CMPU = 2;
    localparam int EV_CMPD = 3;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_UPDOWN = 2'd2,
        MODE_RSVD   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_RISE = 2'd1,
        TB_FALL = 2'd2
    } tb_state_e;

    function automatic logic act_apply(input logic cur, input act_e a);
        logic r;
        unique case (a)
            ACT_HOLD:   r = cur;
            ACT_LOW:    r = 1'b0;
            ACT_HIGH:   r = 1'b1;
            ACT_TOGGLE: r = ~cur;
            default:    r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_aq_prescale.sv
module pwm_aq_prescale
    import pwm_aq_pkg::*;
#(
    parameter int DIV_W = PSC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [DIV_W-1:0] divide,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;

    assign tick = en && !clr && (div_q >= divide);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!en || clr || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // The divider restarts from zero on every tick, so it never exceeds the limit for long
    p_div_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (div_q == '0));

endmodule

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
    import pwm_aq_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NE = NUM_EV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clr,
    input  logic          tick,
    input  cnt_mode_e     mode,
    input  logic [W-1:0]  shd_period,
    input  logic [W-1:0]  shd_compare,
    output logic [W-1:0]  cnt,
    output logic [NE-1:0] fire_d,
    output logic [NE-1:0] ev
);

    tb_state_e     state_q, nxt_state;
    logic [W-1:0]  cnt_q, nxt_cnt;
    logic [W-1:0]  per_q, nxt_per;
    logic [W-1:0]  cmp_q, nxt_cmp;
    logic [NE-1:0] ev_q;
    logic          step_up, wrap, halt;
    logic          is_down, is_updn;

    assign is_down = (mode == MODE_DOWN);
    assign is_updn = (mode == MODE_UPDOWN);

    // Next-state and event decode
    always_comb begin
        nxt_state = state_q;
        nxt_cnt   = cnt_q;
        nxt_per   = per_q;
        nxt_cmp   = cmp_q;
        step_up   = 1'b1;
        wrap      = 1'b0;
        halt      = 1'b0;
        unique case (state_q)
            TB_IDLE: begin
                wrap = 1'b1;
                if (is_down) begin
                    nxt_cnt   = shd_period;
                    step_up   = 1'b0;
                    nxt_state = TB_FALL;
                end else begin
                    nxt_cnt   = '0;
                    nxt_state = TB_RISE;
                end
            end
            TB_RISE: begin
                if (cnt_q >= per_q) begin
                    if (is_updn) begin
                        nxt_cnt   = cnt_q - 1'b1;
                        step_up   = 1'b0;
                        nxt_state = TB_FALL;
                    end else begin
                        nxt_cnt = '0;
                        wrap    = 1'b1;
                    end
                end else begin
                    nxt_cnt = cnt_q + 1'b1;
                end
            end
            TB_FALL: begin
                step_up = 1'b0;
                if (cnt_q == '0) begin
                    nxt_cnt = shd_period;
                    wrap    = 1'b1;
                end else begin
                    nxt_cnt = cnt_q - 1'b1;
                end
            end
            default: nxt_state = TB_IDLE;
        endcase

        // Up-down rebound: reaching zero on the way down opens a new period
        if (is_updn && !step_up && (nxt_cnt == '0)) begin
            wrap      = 1'b1;
            nxt_state = TB_RISE;
        end

        if (wrap) begin
            if (shd_period == '0) begin
                halt      = 1'b1;
                nxt_state = TB_IDLE;
                nxt_cnt   = '0;
            end else begin
                nxt_per = shd_period;
                nxt_cmp = shd_compare;
            end
        end

        fire_d = '0;
        if (tick && !halt) begin
            fire_d[EV_ZERO] = (nxt_cnt == '0);
            fire_d[EV_PEAK] = (nxt_cnt == nxt_per);
            fire_d[EV_CMPU] = (nxt_cnt == nxt_cmp) && step_up;
            fire_d[EV_CMPD] = (nxt_cnt == nxt_cmp) && !step_up;
        end
    end

    // State register and working values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TB_IDLE;
            cnt_q   <= '0;
            per_q   <= '0;
            cmp_q   <= '0;
        end else if (!en || clr) begin
            state_q <= TB_IDLE;
            cnt_q   <= '0;
        end else if (tick) begin
            state_q <= nxt_state;
            cnt_q   <= nxt_cnt;
            per_q   <= nxt_per;
            cmp_q   <= nxt_cmp;
        end
    end

    // Event strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else if (!en || clr) begin
            ev_q <= '0;
        end else begin
            ev_q <= fire_d;
        end
    end

    assign cnt = cnt_q;
    assign ev  = ev_q;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TB_IDLE) |-> (cnt_q <= per_q));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !tick) |=> $stable(cnt_q));

    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q[EV_ZERO] |-> (cnt_q == '0));

    p_peak_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q[EV_PEAK] |-> (cnt_q == per_q));

    p_cmp_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_q[EV_CMPD:EV_CMPU]));

    p_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TB_IDLE) |-> (cnt_q == '0));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((cnt_q == '0) && (ev_q == '0)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((cnt_q == '0) && (state_q == TB_IDLE)));

endmodule

// File: rtl/pwm_aq_action.sv
module pwm_aq_action
    import pwm_aq_pkg::*;
#(
    parameter int NE = NUM_EV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] fire,
    input  act_e          act [NE],
    output logic          wave
);

    logic wave_q, wave_d;

    // Slots are applied in index order: boundary events before compare events
    always_comb begin
        wave_d = wave_q;
        for (int i = 0; i < NE; i++) begin
            if (fire[i]) begin
                wave_d = act_apply(wave_d, act[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else begin
            wave_q <= wave_d;
        end
    end

    assign wave = wave_q;

    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire == '0) |=> $stable(wave_q));

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PSC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cnt_clear,
    input  logic [1:0]    cfg_mode,
    input  logic [PW-1:0] cfg_prescale,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_compare,
    input  logic [1:0]    act_zero,
    input  logic [1:0]    act_period,
    input  logic [1:0]    act_cmp_up,
    input  logic [1:0]    act_cmp_down,
    input  logic          cfg_invert,
    input  logic          cfg_mask_en,
    input  logic          cfg_mask_level,
    output logic          pwm_out,
    output logic [CW-1:0] cnt_value,
    output logic          ev_zero,
    output logic          ev_period,
    output logic          ev_cmp_up,
    output logic          ev_cmp_down
);

    logic              tick;
    logic [NUM_EV-1:0] fire_d;
    logic [NUM_EV-1:0] ev;
    logic              wave;
    act_e              act_tbl [NUM_EV];

    assign act_tbl[EV_ZERO] = act_e'(act_zero);
    assign act_tbl[EV_PEAK] = act_e'(act_period);
    assign act_tbl[EV_CMPU] = act_e'(act_cmp_up);
    assign act_tbl[EV_CMPD] = act_e'(act_cmp_down);

    pwm_aq_prescale #(.DIV_W(PW)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .clr    (cnt_clear),
        .divide (cfg_prescale),
        .tick   (tick)
    );

    pwm_aq_timebase #(.W(CW), .NE(NUM_EV)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .clr         (cnt_clear),
        .tick        (tick),
        .mode        (cnt_mode_e'(cfg_mode)),
        .shd_period  (cfg_period),
        .shd_compare (cfg_compare),
        .cnt         (cnt_value),
        .fire_d      (fire_d),
        .ev          (ev)
    );

    pwm_aq_action #(.NE(NUM_EV)) u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire_d),
        .act   (act_tbl),
        .wave  (wave)
    );

    // Output stage: polarity first, mask last
    always_comb begin
        if (cfg_mask_en) begin
            pwm_out = cfg_mask_level;
        end else begin
            pwm_out = wave ^ cfg_invert;
        end
    end

    assign ev_zero     = ev[EV_ZERO];
    assign ev_period   = ev[EV_PEAK];
    assign ev_cmp_up   = ev[EV_CMPU];
    assign ev_cmp_down = ev[EV_CMPD];

    p_wave_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0) |-> $stable(wave));

endmodule

// File: tb/pwm_aq_channel_bench.sv
`timescale 1ns/1ps
module pwm_aq_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cnt_clear = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [11:0] cfg_prescale = '0;
    logic [15:0] cfg_period = '0;
    logic [15:0] cfg_compare = '0;
    logic [1:0]  act_zero = 2'd0;
    logic [1:0]  act_period = 2'd0;
    logic [1:0]  act_cmp_up = 2'd0;
    logic [1:0]  act_cmp_down = 2'd0;
    logic        cfg_invert = 1'b0;
    logic        cfg_mask_en = 1'b0;
    logic        cfg_mask_level = 1'b0;
    logic        pwm_out;
    logic [15:0] cnt_value;
    logic        ev_zero, ev_period, ev_cmp_up, ev_cmp_down;

    always #2 clk = ~clk;

    pwm_aq_channel u_pwm_aq_channel (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt_clear(cnt_clear),
        .cfg_mode(cfg_mode), .cfg_prescale(cfg_prescale),
        .cfg_period(cfg_period), .cfg_compare(cfg_compare),
        .act_zero(act_zero), .act_period(act_period),
        .act_cmp_up(act_cmp_up), .act_cmp_down(act_cmp_down),
        .cfg_invert(cfg_invert), .cfg_mask_en(cfg_mask_en),
        .cfg_mask_level(cfg_mask_level), .pwm_out(pwm_out),
        .cnt_value(cnt_value), .ev_zero(ev_zero), .ev_period(ev_period),
        .ev_cmp_up(ev_cmp_up), .ev_cmp_down(ev_cmp_down)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    chk_on = 0;
    string tag_cnt = "R12";
    string tag_ev  = "R12";
    string tag_out = "R12";

    // Reference model of the channel, advanced on each rising edge
    int   m_cnt = 0, m_per = 0, m_cmp = 0, m_div = 0;
    bit   m_run = 0, m_up = 1, m_wave = 0;
    bit   m_ev [4];

    function automatic bit act_do(input bit cur, input int a);
        case (a)
            1: return 1'b0;
            2: return 1'b1;
            3: return !cur;
            default: return cur;
        endcase
    endfunction

    task automatic model_step();
        int nx;
        bit up = 1, bnd = 0;
        int md = int'(cfg_mode);
        int sp = int'(cfg_period);
        if (!m_run) begin
            bnd = 1;
            if (md == 1) begin nx = sp; up = 0; end else nx = 0;
        end else if (md == 2) begin
            if (m_up && m_cnt != m_per) nx = m_cnt + 1;
            else begin nx = m_cnt - 1; up = 0; end
            bnd = (!up && nx == 0);
        end else if (md == 1) begin
            up = 0;
            if (m_cnt == 0) begin bnd = 1; nx = sp; end else nx = m_cnt - 1;
        end else begin
            if (m_cnt == m_per) begin bnd = 1; nx = 0; end else nx = m_cnt + 1;
        end
        if (bnd && sp == 0) begin
            m_run = 0; m_cnt = 0;
            return;
        end
        if (bnd) begin m_per = sp; m_cmp = int'(cfg_compare); end
        m_run = 1;
        m_cnt = nx;
        m_up  = bnd ? (md != 1) : up;
        m_ev[0] = (nx == 0);
        m_ev[1] = (nx == m_per);
        m_ev[2] = up && (nx == m_cmp);
        m_ev[3] = !up && (nx == m_cmp);
        if (m_ev[0]) m_wave = act_do(m_wave, int'(act_zero));
        if (m_ev[1]) m_wave = act_do(m_wave, int'(act_period));
        if (m_ev[2]) m_wave = act_do(m_wave, int'(act_cmp_up));
        if (m_ev[3]) m_wave = act_do(m_wave, int'(act_cmp_down));
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_cmp = 0; m_div = 0;
            m_run = 0; m_up = 1; m_wave = 0;
            foreach (m_ev[i]) m_ev[i] = 0;
        end else begin
            foreach (m_ev[i]) m_ev[i] = 0;
            if (!en || cnt_clear) begin
                m_run = 0; m_cnt = 0; m_div = 0;
            end else if (m_div >= int'(cfg_prescale)) begin
                m_div = 0;
                model_step();
            end else begin
                m_div = m_div + 1;
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(tag_cnt, "count", int'(cnt_value), m_cnt);
            check(tag_ev, "ev_zero", int'(ev_zero), int'(m_ev[0]));
            check(tag_ev, "ev_period", int'(ev_period), int'(m_ev[1]));
            check(tag_ev, "ev_cmp_up", int'(ev_cmp_up), int'(m_ev[2]));
            check(tag_ev, "ev_cmp_down", int'(ev_cmp_down), int'(m_ev[3]));
            check(tag_out, "pwm_out", int'(pwm_out),
                  cfg_mask_en ? int'(cfg_mask_level) : int'(m_wave ^ cfg_invert));
        end
    end

    task automatic set_tags(input string c, input string e, input string o);
        tag_cnt = c; tag_ev = e; tag_out = o;
    endtask

    // One configured run; negative step numbers disable the optional stimuli
    task automatic run(input int md, input int psc, input int per, input int cmp,
                       input int aset, input bit inv, input int cycles,
                       input int chg_at, input int new_per, input int new_cmp,
                       input int clr_at, input int msk_from,
                       input string c, input string e, input string o);
        @(negedge clk);
        set_tags("R8", "R8", "R8");
        en = 0;
        repeat (2) @(negedge clk);
        cfg_mode = md[1:0];
        cfg_prescale = psc[11:0];
        cfg_period = per[15:0];
        cfg_compare = cmp[15:0];
        case (aset)
            0: begin act_zero = 2; act_cmp_up = 1; act_period = 0; act_cmp_down = 0; end
            1: begin act_zero = 3; act_cmp_up = 3; act_period = 3; act_cmp_down = 3; end
            default: begin act_zero = 1; act_cmp_up = 2; act_period = 3; act_cmp_down = 1; end
        endcase
        cfg_invert = inv;
        cfg_mask_en = 0;
        @(negedge clk);
        set_tags(c, e, o);
        en = 1;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            cnt_clear = (k == clr_at);
            if (k == clr_at) tag_cnt = "R9";
            if (k == chg_at) begin
                cfg_period = new_per[15:0];
                cfg_compare = new_cmp[15:0];
            end
            if (msk_from >= 0 && k >= msk_from) begin
                cfg_mask_en = 1;
                cfg_mask_level = k[0];
                tag_out = "R11";
            end
        end
        @(negedge clk);
        cnt_clear = 0;
        cfg_mask_en = 0;
    endtask

    initial begin
        chk_on = 1;
        // R12: outputs at reset
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Near-exhaustive sweep over modes, prescale, period, compare and actions (R1, R3, R4)
        for (int md = 0; md < 3; md++)
            for (int psc = 0; psc < 3; psc++)
                for (int per = 1; per <= 4; per++)
                    for (int cmp = 0; cmp < 6; cmp++)
                        for (int a = 0; a < 3; a++) begin
                            int cyc = (psc + 1) * (2 * per + 2) * 2 + 2;
                            run(md, psc, per, cmp, a, (a == 1) && cmp[0], cyc,
                                cyc / 2, (per % 4) + 1, (cmp + 2) % 6,
                                (cmp == 3) ? cyc / 3 : -1,
                                (per == 2 && a == 0) ? cyc - 3 : -1,
                                "R1", "R3", "R4");
                        end

        // R2: long prescale
        for (int md = 0; md < 3; md++)
            run(md, 7, 3, 1, 2, 0, 90, -1, 0, 0, -1, -1, "R2", "R2", "R2");
        // R5: coinciding boundary and compare events
        for (int md = 0; md < 3; md++) begin
            run(md, 0, 3, 0, 1, 0, 30, -1, 0, 0, -1, -1, "R5", "R5", "R5");
            run(md, 0, 3, 3, 2, 0, 30, -1, 0, 0, -1, -1, "R5", "R5", "R5");
        end
        // R6: shadow writes mid-period
        for (int md = 0; md < 3; md++)
            run(md, 1, 5, 2, 2, 0, 60, 7, 2, 1, -1, -1, "R6", "R6", "R6");
        // R7: zero period, from idle and at a boundary
        run(0, 0, 0, 0, 1, 0, 12, -1, 0, 0, -1, -1, "R7", "R7", "R7");
        for (int md = 0; md < 3; md++)
            run(md, 0, 2, 1, 1, 0, 20, 3, 0, 1, -1, -1, "R7", "R7", "R7");
        // R9: clear in every mode
        for (int md = 0; md < 3; md++)
            run(md, 1, 4, 2, 2, 0, 40, -1, 0, 0, 9, -1, "R9", "R9", "R9");
        // R10 and R11: polarity and mask
        for (int md = 0; md < 3; md++) begin
            run(md, 0, 3, 1, 0, 1, 24, -1, 0, 0, -1, -1, "R10", "R10", "R10");
            run(md, 0, 3, 1, 2, 1, 24, -1, 0, 0, -1, 4, "R11", "R11", "R11");
        end

        @(negedge clk);
        en = 0;
        set_tags("R8", "R8", "R8");
        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule